// File: doc/BRIEF.md
# Quadrature to Step/Direction Translator

This block takes the two phase outputs, A and B, of an incremental encoder and turns each valid quadrature edge into one step pulse with a direction level beside it. A motion controller or counter downstream needs only an edge counter gated by the direction level, and no phase decoding of its own. One encoder cycle yields four steps. The step pulse has a fixed width in system clocks. The direction level is written in the same clock edge that raises the step, and it holds between steps.

A and B are asynchronous. They may come from open-collector outputs with pull-ups on the board. Each passes through a flop synchronizer. A tracker state machine has two states: `TRK_WAIT_REF` waits until the synchronizer is filled and then takes the first sample as its reference. `TRK_FOLLOW` compares each later sample against the stored reference. A change of both bits at once is a jump: it emits no step, moves the reference, and sets a sticky error flag. A pulse state machine has three states: `PLS_IDLE`, `PLS_HIGH` (step high, width counted down) and `PLS_GAP` (one low clock). A transition that arrives during `PLS_HIGH` is held in a pending slot and issued from `PLS_GAP`.

The named transitions are:
- `TRK_WAIT_REF` to `TRK_FOLLOW` once the synchronizer is full.
- `PLS_IDLE` to `PLS_HIGH` on an event.
- `PLS_HIGH` to `PLS_GAP` when the count ends.
- `PLS_GAP` to `PLS_HIGH` when a pending or new event exists.
- `PLS_GAP` to `PLS_IDLE` otherwise.

At an 8 MHz clock, a 16-clock pulse plus the one-clock gap gives 17 clocks per step, so the block keeps up with step rates well above 200 kHz.

Top module: `quad_step_xlat`

## Requirements
- R1: While reset is asserted, `step_o`, `dir_o` and `err_o` are all 0.
- R2: After reset, the first synchronized AB value becomes the reference state and produces no step, whatever its value.
- R3: With AB written as {A,B}, the forward order is 00, 10, 11, 01, 00. Each forward single-bit change produces a step with `dir_o` = 1.
- R4: The reverse order is 00, 01, 11, 10, 00. Each reverse single-bit change produces a step with `dir_o` = 0.
- R5: Every single-bit AB change produces exactly one step, so a full cycle gives four steps. No step appears without a change.
- R6: Each step pulse is high for exactly STEP_WIDTH clocks (default 16).
- R7: `dir_o` changes only in the clock edge that raises `step_o` and is stable at all other times.
- R8: With default parameters and the pulse logic idle, `step_o` rises on the fourth rising clock edge after an input change.
- R9: A change of both A and B at once produces no step, replaces the reference with the new value, and sets `err_o`. `err_o` stays 1 until reset.
- R10: A transition that arrives while a pulse is high is held and issued after the pulse ends, with exactly one low clock between the two pulses.
- R11: Reset clears `err_o` and restarts reference capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| step_o | output | 1 | Step pulse, STEP_WIDTH clocks high per valid transition |
| dir_o | output | 1 | Direction: 1 forward, 0 reverse |
| err_o | output | 1 | Sticky flag for a two-bit jump |

## Verification
The inputs start at a non-zero AB value during reset, which shows that the reference is captured rather than assumed to be 00. Full forward and full reverse cycles each start from a different state and separate the two successor rules. A single reversal in mid-cycle shows that direction comes from the last pair of states alone. A two-bit jump followed by a forward move proves that the reference was moved even though no step appeared. Two changes three clocks apart, once in each direction, exercise the pending slot, the one-clock gap, and the direction carried with the held event.

// File: rtl/qsx_pkg.sv
package qsx_pkg;

    typedef enum logic [0:0] {
        TRK_WAIT_REF,
        TRK_FOLLOW
    } trk_state_t;

    typedef enum logic [1:0] {
        PLS_IDLE,
        PLS_HIGH,
        PLS_GAP
    } pls_state_t;

    typedef enum logic [1:0] {
        MV_NONE,
        MV_FWD,
        MV_REV,
        MV_JUMP
    } move_t;

    // AB is packed as {A,B}; forward successor of s is {~s[0], s[1]},
    // reverse successor is {s[0], ~s[1]}.
    function automatic move_t classify_move(input logic [1:0] from_ab,
                                            input logic [1:0] to_ab);
        move_t m;
        if (to_ab == from_ab)
            m = MV_NONE;
        else if (to_ab == {~from_ab[0], from_ab[1]})
            m = MV_FWD;
        else if (to_ab == {from_ab[0], ~from_ab[1]})
            m = MV_REV;
        else
            m = MV_JUMP;
        return m;
    endfunction

endpackage

// File: rtl/qsx_sync.sv
module qsx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] pipe [STAGES];
    logic [STAGES-1:0] fill;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= '0;
                    fill[g] <= 1'b0;
                end else begin
                    pipe[g] <= d_async;
                    fill[g] <= 1'b1;
                end
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[g] <= '0;
                    fill[g] <= 1'b0;
                end else begin
                    pipe[g] <= pipe[g-1];
                    fill[g] <= fill[g-1];
                end
            end
        end
    end

    assign q       = pipe[LAST];
    assign q_valid = fill[LAST];

    // R2
    fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> q_valid);

endmodule

// File: rtl/qsx_track.sv
module qsx_track
    import qsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_i,
    input  logic       ab_vld_i,
    output logic       ev_o,
    output logic       ev_dir_o,
    output logic       err_o
);
    trk_state_t st_q, st_nx;
    logic [1:0] ref_q;
    move_t      mv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRK_WAIT_REF;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        mv    = MV_NONE;
        unique case (st_q)
            TRK_WAIT_REF: if (ab_vld_i) st_nx = TRK_FOLLOW;
            TRK_FOLLOW:   mv = classify_move(ref_q, ab_i);
            default:      st_nx = TRK_WAIT_REF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= '0;
            ev_o     <= 1'b0;
            ev_dir_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            ev_o <= 1'b0;
            unique case (st_q)
                TRK_WAIT_REF: if (ab_vld_i) ref_q <= ab_i;
                TRK_FOLLOW: begin
                    unique case (mv)
                        MV_NONE: ;
                        MV_FWD: begin
                            ev_o     <= 1'b1;
                            ev_dir_o <= 1'b1;
                            ref_q    <= ab_i;
                        end
                        MV_REV: begin
                            ev_o     <= 1'b1;
                            ev_dir_o <= 1'b0;
                            ref_q    <= ab_i;
                        end
                        MV_JUMP: begin
                            err_o <= 1'b1;
                            ref_q <= ab_i;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R2
    ref_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_WAIT_REF) |=> !ev_o);

    // R9
    jump_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv == MV_JUMP) |=> (!ev_o && err_o));

    // R5
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_FOLLOW && ab_i == ref_q) |=> !ev_o);

endmodule

// File: rtl/qsx_pulse.sv
module qsx_pulse
    import qsx_pkg::*;
#(
    parameter int STEP_WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic ev_dir_i,
    output logic step_o,
    output logic dir_o
);
    localparam int CW = $clog2(STEP_WIDTH + 1);
    localparam logic [CW-1:0] LOAD = CW'(STEP_WIDTH - 1);

    pls_state_t st_q, st_nx;
    logic [CW-1:0] cnt_q;
    logic          pend_q, pend_dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PLS_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PLS_IDLE: if (ev_i) st_nx = PLS_HIGH;
            PLS_HIGH: if (cnt_q == '0) st_nx = PLS_GAP;
            PLS_GAP:  st_nx = (pend_q || ev_i) ? PLS_HIGH : PLS_IDLE;
            default:  st_nx = PLS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            pend_q     <= 1'b0;
            pend_dir_q <= 1'b0;
            step_o     <= 1'b0;
            dir_o      <= 1'b0;
        end else begin
            unique case (st_q)
                PLS_IDLE: begin
                    if (ev_i) begin
                        step_o <= 1'b1;
                        dir_o  <= ev_dir_i;
                        cnt_q  <= LOAD;
                    end
                end
                PLS_HIGH: begin
                    if (ev_i) begin
                        pend_q     <= 1'b1;
                        pend_dir_q <= ev_dir_i;
                    end
                    if (cnt_q == '0) step_o <= 1'b0;
                    else             cnt_q  <= cnt_q - 1'b1;
                end
                PLS_GAP: begin
                    if (pend_q) begin
                        step_o     <= 1'b1;
                        dir_o      <= pend_dir_q;
                        cnt_q      <= LOAD;
                        pend_q     <= ev_i;
                        pend_dir_q <= ev_dir_i;
                    end else if (ev_i) begin
                        step_o <= 1'b1;
                        dir_o  <= ev_dir_i;
                        cnt_q  <= LOAD;
                    end
                end
                default: step_o <= 1'b0;
            endcase
        end
    end

    // checker-only length counter
    logic [CW:0] hi_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_len_q <= '0;
        else if (step_o) hi_len_q <= hi_len_q + 1'b1;
        else             hi_len_q <= '0;
    end

    // R6
    step_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_o) |-> (hi_len_q == (CW+1)'(STEP_WIDTH)));

    // R10
    pend_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PLS_GAP && pend_q) |=> $rose(step_o));

    // R10
    pend_only_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PLS_IDLE) |-> !pend_q);

endmodule

// File: rtl/quad_step_xlat.sv
module quad_step_xlat #(
    parameter int SYNC_STAGES = 2,
    parameter int STEP_WIDTH  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enc_a,
    input  logic enc_b,
    output logic step_o,
    output logic dir_o,
    output logic err_o
);
    logic [1:0] ab_s;
    logic       ab_vld;
    logic       ev, ev_dir;

    qsx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({enc_a, enc_b}),
        .q       (ab_s),
        .q_valid (ab_vld)
    );

    qsx_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .ab_i     (ab_s),
        .ab_vld_i (ab_vld),
        .ev_o     (ev),
        .ev_dir_o (ev_dir),
        .err_o    (err_o)
    );

    qsx_pulse #(.STEP_WIDTH(STEP_WIDTH)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .ev_dir_i (ev_dir),
        .step_o   (step_o),
        .dir_o    (dir_o)
    );

    // R7
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(step_o) |-> $stable(dir_o));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!step_o && !dir_o && !err_o));

endmodule

// File: tb/test_quad_step_xlat.sv
module test_quad_step_xlat;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_a = 1'b1;
    logic enc_b = 1'b1;
    logic step_o, dir_o, err_o;

    int checks = 0;
    int errors = 0;
    bit exp_q[$];
    int pulses = 0;
    int last_low = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    quad_step_xlat i_quad_step_xlat (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .step_o(step_o), .dir_o(dir_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: new AB value; exp_dir < 0 means no step expected
    task automatic move(input logic [1:0] ab, input int exp_dir);
        @(negedge clk);
        {enc_a, enc_b} = ab;
        if (exp_dir >= 0) exp_q.push_back(exp_dir[0]);
    endtask

    // monitor / scoreboard
    bit prev_step = 0;
    bit prev_dir = 0;
    int hi_cnt = 0;
    int lo_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_step = 0; prev_dir = 0; hi_cnt = 0; lo_cnt = 0;
        end else begin
            if (step_o && !prev_step) begin
                pulses++;
                last_low = lo_cnt;
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected step", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(dir_o == e, "R3 R4 direction at step", dir_o, e);
                end
                hi_cnt = 1;
            end else if (step_o) begin
                hi_cnt++;
                check(dir_o == prev_dir, "R7 dir stable in pulse", dir_o, prev_dir);
            end else begin
                if (prev_step) check(hi_cnt == 16, "R6 pulse width", hi_cnt, 16);
                if (prev_step) lo_cnt = 0;
                lo_cnt++;
                if (!prev_step)
                    check(dir_o == prev_dir, "R7 dir stable idle", dir_o, prev_dir);
            end
            prev_step = step_o;
            prev_dir  = dir_o;
        end
    end

    initial begin
        int base;
        int lat;
        // R1 during reset, AB = 11
        waitn(4);
        check(step_o == 0 && dir_o == 0 && err_o == 0, "R1 reset outputs",
              {step_o, dir_o, err_o}, 0);
        rst_n = 1'b1;
        waitn(12);
        check(pulses == 0, "R2 no step for first sample", pulses, 0);

        // R3 forward cycle from 11
        move(2'b01, 1); waitn(30);
        move(2'b00, 1); waitn(30);
        move(2'b10, 1); waitn(30);
        move(2'b11, 1); waitn(30);
        check(pulses == 4, "R5 four steps per cycle", pulses, 4);
        check(dir_o == 1, "R3 forward level", dir_o, 1);

        // R8 latency
        move(2'b01, 1);
        lat = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (step_o) begin lat = i; break; end
        end
        check(lat == 4, "R8 latency", lat, 4);
        waitn(30);

        // R4 reverse cycle from 01
        base = pulses;
        move(2'b11, 0); waitn(30);
        move(2'b10, 0); waitn(30);
        move(2'b00, 0); waitn(30);
        move(2'b01, 0); waitn(30);
        move(2'b11, 0); waitn(30);
        check(pulses - base == 5, "R4 R5 reverse count", pulses - base, 5);
        check(dir_o == 0, "R4 reverse level", dir_o, 0);

        // R9 two-bit jump 11 -> 00
        base = pulses;
        move(2'b00, -1); waitn(30);
        check(pulses == base, "R9 jump gives no step", pulses - base, 0);
        check(err_o == 1, "R9 error set", err_o, 1);
        move(2'b10, 1); waitn(30);
        check(pulses - base == 1, "R9 reference moved", pulses - base, 1);
        check(err_o == 1, "R9 error sticky", err_o, 1);

        // R10 pending, forward then reverse
        base = pulses;
        move(2'b11, 1); waitn(3);
        move(2'b01, 1); waitn(60);
        check(pulses - base == 2, "R10 held step issued", pulses - base, 2);
        check(last_low == 1, "R10 one low clock gap", last_low, 1);
        move(2'b11, 0); waitn(3);
        move(2'b10, 0); waitn(60);
        check(pulses - base == 4, "R10 held reverse step", pulses - base, 4);
        check(last_low == 1, "R10 gap reverse", last_low, 1);

        // R11 reset clears error
        @(negedge clk); rst_n = 1'b0;
        waitn(3);
        check(err_o == 0 && step_o == 0 && dir_o == 0, "R11 R1 reset clears",
              {step_o, dir_o, err_o}, 0);
        rst_n = 1'b1;
        waitn(12);
        base = pulses;
        move(2'b11, 1); waitn(30);
        check(pulses - base == 1, "R11 tracking after reset", pulses - base, 1);
        check(exp_q.size() == 0, "R5 all expected steps seen", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule